// File: doc/BRIEF.md
# Fractional tap modulation sequencer

This block steers an oscillator whose speed is chosen from a small set of adjacent taps. For every clock cycle it names the tap to use, either a coarse tap N or its upper neighbour N+1, so that the average rate over a frame falls between the two. The number of upper-tap cycles in each frame is set by a modulation value, which gives a fine step between two coarse steps.

A single control word carries both settings. The block takes a new word only at the end of a frame, so a frame never mixes two settings. Upper-tap cycles are spread through the frame by a carry accumulator, or bunched at the start of the frame in a simpler build variant. When the coarse tap is already the highest one, there is no upper neighbour, and the modulation value has no effect. A one-cycle strobe marks the first cycle of every frame, so a tuning loop can line up its frequency counts with the frames.

Top module: `frac_tap_seq`

## Requirements
- R1: The control word holds the coarse tap in bits 7:5 and the modulation value in bits 4:0 (default widths of 3 and 5 bits).
- R2: In every 32-cycle frame with coarse tap N below 7 and modulation value M, tap N+1 is output on exactly M cycles and tap N on the other 32-M cycles.
- R3: When the latched coarse tap is 7, tap 7 is output on every cycle of the frame, whatever the modulation value.
- R4: In the spread variant (default), frame position k (0 to 31) outputs N+1 exactly when floor((k+1)*M/32) is greater than floor(k*M/32).
- R5: frame_start is high on position 0 of each frame and low on the other 31 positions, so it pulses once every 32 cycles.
- R6: The control word is sampled only on the last cycle of a frame and takes effect from the next position 0. A change during a frame has no effect on that frame.
- R7: An active-low asynchronous reset clears the frame position, the accumulator and the latched setting (tap 0, modulation 0). The first cycle after reset is position 0 with frame_start high, and the first frame outputs tap 0 throughout.
- R8: In the bunched variant, positions 0 to M-1 output N+1 and the remaining positions output N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tap decision per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_word | input | 8 | Coarse tap (bits 7:5) and modulation value (bits 4:0) |
| tap_sel | output | 3 | Tap chosen for the current cycle |
| frame_start | output | 1 | High on the first cycle of each frame |

## Verification
The bench builds two copies with the default widths of 3 and 5 bits side by side: one uses the spread variant and one the bunched variant. Both copies see the same control word, so each frame is checked at every position against both the carry formula and the bunched layout. With 32-cycle frames, the extreme modulation values 0 and 31, the highest coarse tap, mid-frame word changes and a reset in the middle of a frame are all reached in a few hundred cycles.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
   // Placement of the upper-tap cycles within a frame
   typedef enum logic {
      SPREAD_BURST = 1'b0,
      SPREAD_EVEN  = 1'b1
   } spread_e;
endpackage

// File: rtl/fts_frame_ctr.sv
`timescale 1ns/1ps
module fts_frame_ctr #(
   parameter int MOD_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [MOD_W-1:0] pos,
   output logic             first,
   output logic             last
);
   localparam logic [MOD_W-1:0] POS_LAST = {MOD_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= pos + 1'b1;
   end

   assign first = (pos == '0);
   assign last  = (pos == POS_LAST);
endmodule

// File: rtl/fts_cfg_hold.sv
`timescale 1ns/1ps
module fts_cfg_hold #(
   parameter int TAP_W = 3,
   parameter int MOD_W = 5,
   localparam int WORD_W = TAP_W + MOD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic [TAP_W-1:0]  tap_q,
   output logic [MOD_W-1:0]  mod_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= '0;
         mod_q <= '0;
      end else if (load) begin
         tap_q <= word_in[WORD_W-1:MOD_W];
         mod_q <= word_in[MOD_W-1:0];
      end
   end
endmodule

// File: rtl/fts_spread.sv
`timescale 1ns/1ps
module fts_spread
   import fts_pkg::*;
#(
   parameter int      MOD_W  = 5,
   parameter spread_e SPREAD = SPREAD_EVEN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MOD_W-1:0] pos,
   input  logic [MOD_W-1:0] mod,
   output logic             hi
);
   localparam logic [MOD_W-1:0] POS_LAST = {MOD_W{1'b1}};

   generate
      if (SPREAD == SPREAD_EVEN) begin : g_even
         logic [MOD_W-1:0] acc;
         logic [MOD_W:0]   sum;

         assign sum = {1'b0, acc} + {1'b0, mod};
         assign hi  = sum[MOD_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               acc <= '0;
            else if (pos == POS_LAST) acc <= '0;
            else                      acc <= sum[MOD_W-1:0];
         end
      end else begin : g_burst
         assign hi = (pos < mod);
      end
   endgenerate
endmodule

// File: rtl/frac_tap_seq.sv
`timescale 1ns/1ps
module frac_tap_seq
   import fts_pkg::*;
#(
   parameter int      TAP_W  = 3,
   parameter int      MOD_W  = 5,
   parameter spread_e SPREAD = SPREAD_EVEN
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TAP_W+MOD_W-1:0] ctl_word,
   output logic [TAP_W-1:0]       tap_sel,
   output logic                   frame_start
);
   localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};

   generate
      if (TAP_W < 1 || TAP_W > 8) begin : g_bad_tap
         $error("frac_tap_seq: TAP_W out of range");
      end
      if (MOD_W < 1 || MOD_W > 16) begin : g_bad_mod
         $error("frac_tap_seq: MOD_W out of range");
      end
   endgenerate

   logic [MOD_W-1:0] pos;
   logic             pos_first;
   logic             pos_last;
   logic [TAP_W-1:0] tap_q;
   logic [MOD_W-1:0] mod_q;
   logic             up_pick;

   fts_frame_ctr #(.MOD_W(MOD_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos),
      .first (pos_first),
      .last  (pos_last)
   );

   fts_cfg_hold #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pos_last),
      .word_in (ctl_word),
      .tap_q   (tap_q),
      .mod_q   (mod_q)
   );

   fts_spread #(.MOD_W(MOD_W), .SPREAD(SPREAD)) u_spr (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos),
      .mod   (mod_q),
      .hi    (up_pick)
   );

   always_comb begin
      if (up_pick && (tap_q != TAP_TOP)) tap_sel = tap_q + 1'b1;
      else                               tap_sel = tap_q;
   end

   assign frame_start = pos_first;
endmodule

// File: rtl/fts_checker.sv
`timescale 1ns/1ps
module fts_checker #(
   parameter int TAP_W = 3,
   parameter int MOD_W = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [TAP_W+MOD_W-1:0] ctl_word,
   input logic [TAP_W-1:0]       tap_sel,
   input logic                   frame_start
);
   localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};
   localparam logic [MOD_W-1:0] GLAST = {MOD_W{1'b1}};

   logic [MOD_W-1:0] gap;
   logic [TAP_W-1:0] sh_tap;
   logic [MOD_W-1:0] sh_mod;
   logic [MOD_W:0]   hi_cnt;
   logic [TAP_W-1:0] sh_up;
   logic [MOD_W:0]   hi_fin;
   logic [MOD_W:0]   hi_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap    <= '0;
         sh_tap <= '0;
         sh_mod <= '0;
         hi_cnt <= '0;
      end else begin
         gap <= gap + 1'b1;
         if (gap == GLAST) begin
            sh_tap <= ctl_word[TAP_W+MOD_W-1:MOD_W];
            sh_mod <= ctl_word[MOD_W-1:0];
            hi_cnt <= '0;
         end else if (tap_sel != sh_tap) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   assign sh_up  = sh_tap + 1'b1;
   assign hi_fin = hi_cnt + {{MOD_W{1'b0}}, (tap_sel != sh_tap)};
   assign hi_exp = (sh_tap == TOP) ? '0 : {1'b0, sh_mod};

   a_r5_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start == (gap == '0));

   a_r6_frame_setting: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_sel == sh_tap) || ((sh_tap != TOP) && (tap_sel == sh_up)));

   a_r3_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_tap == TOP) |-> (tap_sel == TOP));

   a_r2_frame_total: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == GLAST) |-> (hi_fin == hi_exp));
endmodule

bind frac_tap_seq fts_checker #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_word    (ctl_word),
   .tap_sel     (tap_sel),
   .frame_start (frame_start)
);

// File: tb/sim_frac_tap_seq.sv
`timescale 1ns/1ps
module sim_frac_tap_seq;
   import fts_pkg::*;

   localparam int FR = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ctl_word = 8'h00;
   logic [2:0] tap_e, tap_b;
   logic       fs_e, fs_b;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   frac_tap_seq #(.TAP_W(3), .MOD_W(5), .SPREAD(SPREAD_EVEN)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
      .tap_sel(tap_e), .frame_start(fs_e));

   frac_tap_seq #(.TAP_W(3), .MOD_W(5), .SPREAD(SPREAD_BURST)) u1 (
      .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
      .tap_sel(tap_b), .frame_start(fs_b));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_even(int n, int m, int k);
      if (n == 7) return 7;
      return n + (((k + 1) * m) / FR - (k * m) / FR);
   endfunction

   function automatic int exp_burst(int n, int m, int k);
      if (n == 7) return 7;
      return n + ((k < m) ? 1 : 0);
   endfunction

   // Go to the next frame start, present a word, land on the frame using it
   task automatic apply(input logic [7:0] w);
      do @(negedge clk); while (!fs_e);
      ctl_word = w;
      repeat (FR) @(negedge clk);
   endtask

   // Called at position 0 of a frame using w; ends at position 31
   task automatic check_frame(input logic [7:0] w, input bit chg,
                              input logic [7:0] w2, input string req);
      int n, m, ups;
      n = int'(w[7:5]);
      m = int'(w[4:0]);
      ups = 0;
      for (int k = 0; k < FR; k++) begin
         chk(fs_e == (k == 0), "R5", "frame_start", int'(fs_e), (k == 0) ? 1 : 0);
         chk(int'(tap_e) == exp_even(n, m, k), req, $sformatf("even tap pos %0d", k),
             int'(tap_e), exp_even(n, m, k));
         chk(int'(tap_b) == exp_burst(n, m, k), "R8", $sformatf("burst tap pos %0d", k),
             int'(tap_b), exp_burst(n, m, k));
         if (int'(tap_e) != n) ups++;
         if (chg && k == 10) ctl_word = w2;
         if (k < FR - 1) @(negedge clk);
      end
      chk(ups == ((n == 7) ? 0 : m), "R2", "upper-tap count", ups, (n == 7) ? 0 : m);
   endtask

   task automatic t_reset;
      chk(fs_e == 1'b1, "R7", "frame_start after reset", int'(fs_e), 1);
      chk(tap_e == 3'd0, "R7", "tap after reset", int'(tap_e), 0);
      ctl_word = 8'hFF;
      check_frame(8'h00, 1'b0, 8'h00, "R7");
   endtask

   task automatic t_pack;
      // R1: 101_01011 -> tap 5, modulation 11
      apply(8'b101_01011);
      check_frame(8'b101_01011, 1'b0, 8'h00, "R1");
      // R1: 010_11000 -> tap 2, modulation 24
      apply(8'b010_11000);
      check_frame(8'b010_11000, 1'b0, 8'h00, "R1");
   endtask

   task automatic t_counts;
      apply({3'd0, 5'd0});  check_frame({3'd0, 5'd0}, 1'b0, 8'h00, "R2");
      apply({3'd3, 5'd1});  check_frame({3'd3, 5'd1}, 1'b0, 8'h00, "R4");
      apply({3'd1, 5'd16}); check_frame({3'd1, 5'd16}, 1'b0, 8'h00, "R4");
      apply({3'd6, 5'd31}); check_frame({3'd6, 5'd31}, 1'b0, 8'h00, "R4");
      apply({3'd4, 5'd7});  check_frame({3'd4, 5'd7}, 1'b0, 8'h00, "R4");
   endtask

   task automatic t_top;
      apply({3'd7, 5'd31}); check_frame({3'd7, 5'd31}, 1'b0, 8'h00, "R3");
      apply({3'd7, 5'd13}); check_frame({3'd7, 5'd13}, 1'b0, 8'h00, "R3");
   endtask

   task automatic t_mid_change;
      apply({3'd2, 5'd5});
      check_frame({3'd2, 5'd5}, 1'b1, {3'd5, 5'd20}, "R6");
      @(negedge clk);
      check_frame({3'd5, 5'd20}, 1'b0, 8'h00, "R6");
   endtask

   task automatic t_reset_mid;
      apply({3'd3, 5'd9});
      repeat (12) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(tap_e == 3'd0, "R7", "tap during reset", int'(tap_e), 0);
      @(negedge clk);
      rst_n = 1'b1;
      chk(fs_e == 1'b1, "R7", "frame_start at release", int'(fs_e), 1);
      check_frame(8'h00, 1'b0, 8'h00, "R7");
      @(negedge clk);
      check_frame({3'd3, 5'd9}, 1'b0, 8'h00, "R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pack();
      t_counts();
      t_top();
      t_mid_change();
      t_reset_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule